// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits beside one 32 KB block of a byte-wide nonvolatile memory and watches the stream of qualified writes, each an address and data pair. It recognises two command sequences. The first is a three-write key that sets protection and also grants one write cycle. The second is a six-write sequence that clears protection. For every write it returns a decision: the write is forwarded to the array, or it is withheld. Withheld writes are either command steps or writes refused because the block is protected.

The protection flag sits in its own reset domain, which is driven by a dedicated "keep" reset. The ordinary logic reset models power transitions. It clears the matcher and any half-entered command, but leaves the protection flag untouched. A state change requested by a completed sequence is only committed when the page-programming logic signals the end of the write cycle. The block does not hold page data or program timing. A memory with several blocks uses one instance per block, fed with block-relative addresses.

Top module: `wrprot_cmd_detect`

## Requirements
- R1: After both resets are applied and released, prot_on is 0, prot_chg is 0 and dec_vld is 0.
- R2: With protection off and no command in progress, any write that is not a command step returns dec_allow=1, dec_cmd=0.
- R3: The key writes are data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Each step returns dec_cmd=1 and dec_allow=0. At the next cyc_end, prot_on becomes 1 and prot_chg pulses for one cycle if it was 0, even when no data write followed.
- R4: With protection on, a write that is not preceded by the key returns dec_allow=0, dec_cmd=0, and leaves prot_on unchanged.
- R5: After the key, up to PAGE_BYTES (64) data writes return dec_allow=1. Any further write in the same cycle falls back to the rule of R2/R4. Committing a key while prot_on is already 1 gives no prot_chg pulse.
- R6: The clear sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Each step is a command step. After the sequence, data writes are allowed, and at the next cyc_end prot_on becomes 0 with a prot_chg pulse.
- R7: A write that does not match the next expected step returns the matcher to idle and is decided as an ordinary write. It is not re-tried as a first step.
- R8: prot_on changes only at a cyc_end, never on a write.
- R9: rst_n does not change prot_on and discards any half-entered or completed but uncommitted sequence. Only keep_rst_n clears prot_on.
- R10: A write in the same cycle as cyc_end is decided with the state from before that cycle. A sequence whose final step lands with cyc_end is not committed.
- R11: dec_vld is 1 exactly in the cycle after each cycle with wr_valid=1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low logic reset (power transition) |
| keep_rst_n | input | 1 | Asynchronous active-low reset of the stored protect flag |
| wr_valid | input | 1 | Qualified write strobe, one cycle per write |
| wr_addr | input | 15 | Block-relative write address |
| wr_data | input | 8 | Write data byte |
| cyc_end | input | 1 | End of the write cycle; commits a requested state change |
| dec_vld | output | 1 | Decision valid, one cycle after each write |
| dec_allow | output | 1 | The write may reach the array |
| dec_cmd | output | 1 | The write was a command step |
| prot_on | output | 1 | Current protect state |
| prot_chg | output | 1 | One-cycle pulse when prot_on changed |

## Verification
Two things can land in the same clock: a write being decided, and the end-of-cycle commit that moves the matcher and the protect flag. The bench drives wr_valid and cyc_end together in two cases. In the first, a data write inside an open key window must still be allowed. In the second, the last step of the clear sequence must be reported as a command step while prot_on keeps its old value and no change pulse appears. A later lone cyc_end must then also commit nothing.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Position inside the command sequences
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_X3   = 3'd3,
    ST_X4   = 3'd4,
    ST_X5   = 3'd5,
    ST_OPEN = 3'd6
  } step_e;

  // State change requested by a completed sequence, pending commit
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_SET  = 2'd1,
    PEND_CLR  = 2'd2
  } pend_e;

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  // asserts at once, releases after STAGES clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_pkg::*;
#(
  parameter int              ADDR_W     = 15,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] CODE_LEAD  = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_FOLL  = 8'h55,
  parameter logic [DATA_W-1:0] CODE_SET   = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_ARM   = 8'h80,
  parameter logic [DATA_W-1:0] CODE_CLR   = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cyc_end,
  output logic              cmd_hit,
  output logic              win_open,
  output pend_e             pend_q
);

  step_e st_q, st_nxt;
  pend_e pend_nxt;
  logic  at_a, at_b;
  logic  is_lead_a, is_foll_b, is_set_a, is_arm_a, is_clr_a;

  assign at_a      = (wr_addr == KEY_ADDR_A);
  assign at_b      = (wr_addr == KEY_ADDR_B);
  assign is_lead_a = at_a && (wr_data == CODE_LEAD);
  assign is_foll_b = at_b && (wr_data == CODE_FOLL);
  assign is_set_a  = at_a && (wr_data == CODE_SET);
  assign is_arm_a  = at_a && (wr_data == CODE_ARM);
  assign is_clr_a  = at_a && (wr_data == CODE_CLR);

  always_comb begin
    cmd_hit  = 1'b0;
    st_nxt   = st_q;
    pend_nxt = pend_q;
    if (wr_valid) begin
      case (st_q)
        ST_IDLE: if (is_lead_a) begin cmd_hit = 1'b1; st_nxt = ST_K1; end
        ST_K1:   if (is_foll_b) begin cmd_hit = 1'b1; st_nxt = ST_K2; end
        ST_K2: begin
          if (is_set_a) begin
            cmd_hit  = 1'b1;
            st_nxt   = ST_OPEN;
            pend_nxt = PEND_SET;
          end else if (is_arm_a) begin
            cmd_hit = 1'b1;
            st_nxt  = ST_X3;
          end
        end
        ST_X3:   if (is_lead_a) begin cmd_hit = 1'b1; st_nxt = ST_X4; end
        ST_X4:   if (is_foll_b) begin cmd_hit = 1'b1; st_nxt = ST_X5; end
        ST_X5: begin
          if (is_clr_a) begin
            cmd_hit  = 1'b1;
            st_nxt   = ST_OPEN;
            pend_nxt = PEND_CLR;
          end
        end
        default: ;
      endcase
      // a miss drops any partial sequence; no re-try as first step
      if (!cmd_hit && (st_q != ST_OPEN)) st_nxt = ST_IDLE;
    end
    if (cyc_end) begin
      st_nxt   = ST_IDLE;
      pend_nxt = PEND_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= PEND_NONE;
    end else begin
      st_q   <= st_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign win_open = (st_q == ST_OPEN);

endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate #(
  parameter int PAGE_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic cyc_end,
  input  logic cmd_hit,
  input  logic win_open,
  input  logic prot_on,
  output logic dec_vld,
  output logic dec_allow,
  output logic dec_cmd
);

  localparam int              CNT_W   = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             room, allow_d, dec_en;

  assign room = (cnt_q < CNT_MAX);

  always_comb begin
    if (cmd_hit)              allow_d = 1'b0;
    else if (win_open && room) allow_d = 1'b1;
    else                      allow_d = !prot_on;
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (cyc_end || !win_open)  cnt_nxt = '0;
    else if (wr_valid && room) cnt_nxt = cnt_q + 1'b1;
  end

  assign dec_en = wr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      dec_vld   <= 1'b0;
      dec_allow <= 1'b0;
      dec_cmd   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      dec_vld <= wr_valid;
      if (dec_en) begin
        dec_allow <= allow_d;
        dec_cmd   <= cmd_hit;
      end
    end
  end

endmodule

// File: rtl/wp_state_reg.sv
module wp_state_reg
  import wp_pkg::*;
(
  input  logic  clk,
  input  logic  keep_rst_n,
  input  logic  cyc_end,
  input  pend_e pend,
  output logic  prot_on,
  output logic  prot_chg
);

  logic prot_d, prot_en, chg_d;

  always_comb begin
    case (pend)
      PEND_SET: prot_d = 1'b1;
      PEND_CLR: prot_d = 1'b0;
      default:  prot_d = prot_on;
    endcase
  end

  assign prot_en = cyc_end;
  assign chg_d   = cyc_end && (prot_d != prot_on);

  always_ff @(posedge clk or negedge keep_rst_n) begin
    if (!keep_rst_n) begin
      prot_on  <= 1'b0;
      prot_chg <= 1'b0;
    end else begin
      prot_chg <= chg_d;
      if (prot_en) prot_on <= prot_d;
    end
  end

endmodule

// File: rtl/wrprot_cmd_detect.sv
module wrprot_cmd_detect
  import wp_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keep_rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cyc_end,
  output logic              dec_vld,
  output logic              dec_allow,
  output logic              dec_cmd,
  output logic              prot_on,
  output logic              prot_chg
);

  logic  core_rst_n, keep_sync_n;
  logic  cmd_hit, win_open;
  pend_e pend;

  wp_rst_sync #(.STAGES(2)) u_core_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  wp_rst_sync #(.STAGES(2)) u_keep_rst (
    .clk(clk), .arst_n(keep_rst_n), .srst_n(keep_sync_n)
  );

  wp_seq_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst_n(core_rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cyc_end(cyc_end),
    .cmd_hit(cmd_hit), .win_open(win_open), .pend_q(pend)
  );

  wp_write_gate #(.PAGE_BYTES(PAGE_BYTES)) u_gate (
    .clk(clk), .rst_n(core_rst_n),
    .wr_valid(wr_valid), .cyc_end(cyc_end),
    .cmd_hit(cmd_hit), .win_open(win_open), .prot_on(prot_on),
    .dec_vld(dec_vld), .dec_allow(dec_allow), .dec_cmd(dec_cmd)
  );

  wp_state_reg u_state (
    .clk(clk), .keep_rst_n(keep_sync_n),
    .cyc_end(cyc_end), .pend(pend),
    .prot_on(prot_on), .prot_chg(prot_chg)
  );

endmodule

// File: rtl/wrprot_cmd_detect_chk.sv
module wrprot_cmd_detect_chk (
  input logic clk,
  input logic core_n,
  input logic keep_n,
  input logic wr_valid,
  input logic cyc_end,
  input logic cmd_hit,
  input logic win_open,
  input logic prot_on,
  input logic prot_chg,
  input logic dec_vld,
  input logic dec_allow,
  input logic dec_cmd
);

  a_r11_dec_after_wr: assert property (@(posedge clk) disable iff (!core_n)
    wr_valid |=> dec_vld);

  a_r11_no_spurious_dec: assert property (@(posedge clk) disable iff (!core_n)
    !wr_valid |=> !dec_vld);

  a_r8_prot_moves_on_end: assert property (@(posedge clk) disable iff (!core_n || !keep_n)
    !cyc_end |=> $stable(prot_on));

  a_r3_chg_marks_change: assert property (@(posedge clk) disable iff (!keep_n)
    prot_chg |-> (prot_on != $past(prot_on)));

  a_r9_fall_needs_end: assert property (@(posedge clk) disable iff (!keep_n)
    $fell(prot_on) |-> $past(cyc_end));

  a_r4_locked_denied: assert property (@(posedge clk) disable iff (!core_n)
    (wr_valid && prot_on && !win_open) |=> !dec_allow);

  a_r10_cmd_withheld: assert property (@(posedge clk) disable iff (!core_n)
    cmd_hit |=> (dec_cmd && !dec_allow));

endmodule

bind wrprot_cmd_detect wrprot_cmd_detect_chk u_chk (
  .clk(clk), .core_n(core_rst_n), .keep_n(keep_sync_n),
  .wr_valid(wr_valid), .cyc_end(cyc_end),
  .cmd_hit(cmd_hit), .win_open(win_open),
  .prot_on(prot_on), .prot_chg(prot_chg),
  .dec_vld(dec_vld), .dec_allow(dec_allow), .dec_cmd(dec_cmd)
);

// File: tb/wrprot_cmd_detect_tb.sv
module wrprot_cmd_detect_tb;

  logic        clk = 1'b0;
  logic        rst_n, keep_rst_n, wr_valid, cyc_end;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        dec_vld, dec_allow, dec_cmd, prot_on, prot_chg;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wrprot_cmd_detect u_dut (
    .clk(clk), .rst_n(rst_n), .keep_rst_n(keep_rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cyc_end(cyc_end),
    .dec_vld(dec_vld), .dec_allow(dec_allow), .dec_cmd(dec_cmd),
    .prot_on(prot_on), .prot_chg(prot_chg)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [14:0] a, input logic [7:0] d, input logic e,
                       input logic exp_allow, input logic exp_cmd, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; cyc_end = e;
    @(negedge clk);
    wr_valid = 1'b0; cyc_end = 1'b0;
    chk({tag, " dec_vld"},   dec_vld,   1'b1);
    chk({tag, " dec_allow"}, dec_allow, exp_allow);
    chk({tag, " dec_cmd"},   dec_cmd,   exp_cmd);
  endtask

  task automatic do_end(input logic exp_prot, input logic exp_chg, input string tag);
    @(negedge clk);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    chk({tag, " prot_on"},  prot_on,  exp_prot);
    chk({tag, " prot_chg"}, prot_chg, exp_chg);
  endtask

  task automatic send_key(input string tag);
    do_wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, tag);
    do_wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, tag);
    do_wr(15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; keep_rst_n = 1'b0;
    wr_valid = 1'b0; cyc_end = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; keep_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 prot_on", prot_on, 1'b0);
    chk("R1 prot_chg", prot_chg, 1'b0);
    chk("R1 dec_vld", dec_vld, 1'b0);
  endtask

  task automatic t_plain();
    do_wr(15'h1234, 8'h5A, 1'b0, 1'b1, 1'b0, "R2 plain");
    @(negedge clk);
    chk("R11 dec_vld drops", dec_vld, 1'b0);
    do_wr(15'h5555, 8'h11, 1'b0, 1'b1, 1'b0, "R2 key addr wrong data");
  endtask

  task automatic t_enable();
    send_key("R3 key step");
    chk("R8 prot before end", prot_on, 1'b0);
    do_end(1'b1, 1'b1, "R3 commit");
    @(negedge clk);
    chk("R3 chg one cycle", prot_chg, 1'b0);
  endtask

  task automatic t_locked();
    do_wr(15'h0100, 8'h33, 1'b0, 1'b0, 1'b0, "R4 locked write");
    do_end(1'b1, 1'b0, "R4 no change");
  endtask

  task automatic t_window();
    send_key("R5 key step");
    for (int i = 0; i < 64; i++)
      do_wr(15'(16'h0200 + i), 8'(i), 1'b0, 1'b1, 1'b0, "R5 data in window");
    do_wr(15'h0300, 8'hEE, 1'b0, 1'b0, 1'b0, "R5 beyond page");
    do_end(1'b1, 1'b0, "R5 re-key no chg");
  endtask

  task automatic t_mismatch();
    do_wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R7 first step");
    do_wr(15'h2AAB, 8'h55, 1'b0, 1'b0, 1'b0, "R7 wrong addr");
    do_wr(15'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, "R7 no resume");
    do_end(1'b1, 1'b0, "R7 state kept");
  endtask

  task automatic t_power();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 prot survives rst_n", prot_on, 1'b1);
    send_key("R9 key step");
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_wr(15'h0400, 8'h44, 1'b0, 1'b0, 1'b0, "R9 key lost");
    do_end(1'b1, 1'b0, "R9 nothing pending");
  endtask

  task automatic t_same_cycle();
    send_key("R10 key step");
    do_wr(15'h0500, 8'h77, 1'b1, 1'b1, 1'b0, "R10 data with end");
    chk("R10 prot after end", prot_on, 1'b1);
    do_wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R6 clr step1");
    do_wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R6 clr step2");
    do_wr(15'h5555, 8'h80, 1'b0, 1'b0, 1'b1, "R6 clr step3");
    do_wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R6 clr step4");
    do_wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R6 clr step5");
    do_wr(15'h5555, 8'h20, 1'b1, 1'b0, 1'b1, "R10 last step with end");
    chk("R10 no commit prot", prot_on, 1'b1);
    chk("R10 no commit chg", prot_chg, 1'b0);
    do_end(1'b1, 1'b0, "R10 lone end");
  endtask

  task automatic t_disable();
    do_wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R6 step1");
    do_wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R6 step2");
    do_wr(15'h5555, 8'h80, 1'b0, 1'b0, 1'b1, "R6 step3");
    do_wr(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R6 step4");
    do_wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R6 step5");
    do_wr(15'h5555, 8'h20, 1'b0, 1'b0, 1'b1, "R6 step6");
    chk("R8 prot before end", prot_on, 1'b1);
    do_wr(15'h0600, 8'h99, 1'b0, 1'b1, 1'b0, "R6 data after clr");
    do_end(1'b0, 1'b1, "R6 commit");
    do_wr(15'h0700, 8'h12, 1'b0, 1'b1, 1'b0, "R2 after clr");
  endtask

  task automatic t_keep();
    send_key("R9 rekey");
    do_end(1'b1, 1'b1, "R9 rekey commit");
    @(negedge clk); keep_rst_n = 1'b0;
    repeat (2) @(negedge clk); keep_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 keep reset clears", prot_on, 1'b0);
    do_wr(15'h0800, 8'h21, 1'b0, 1'b1, 1'b0, "R9 open after keep");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_enable();
    t_locked();
    t_window();
    t_mismatch();
    t_power();
    t_same_cycle();
    t_disable();
    t_keep();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule